// File: doc/BRIEF.md
# Dual-Phase Programmable Reference Divider

This block divides a single reference clock by a programmable ratio and serves two phase-locked loops from that one divider. Over each divided period the block makes a square-ish waveform. It emits a one-cycle comparison strobe for loop A when that waveform rises, and another for loop B when it falls. The two comparison events therefore always land on different reference cycles, so the two loops' phase detectors never fire together.

A select bit inserts an extra divide-by-two in loop B's path only, which halves loop B's comparison rate. The ratio and the select bit are sampled only at the divider's terminal count, so every output period is whole. The block also passes the incoming reference straight through as a buffered copy for other consumers.

Top module: `refdiv_dual`

## Requirements
- R1: With the select bit low and a steady ratio R (8..4095), `strobe_a_o` pulses once every R reference cycles. The first pulse comes in the R-th cycle after the first clock edge with reset low.
- R2: A programmed ratio below 8, including 0, behaves exactly as a ratio of 8.
- R3: With the select bit low, `strobe_b_o` pulses floor(R/2) cycles after each `strobe_a_o` pulse, and also repeats every R cycles.
- R4: `strobe_a_o` and `strobe_b_o` are never high in the same cycle.
- R5: With the select bit high, loop B's strobe fires on only every second falling edge of the divided signal. The first falling edge after the setting takes effect fires, and then every 2R cycles.
- R6: A new ratio or select value is taken only in the cycle in which the divider wraps to its next period. A change at any other time has no effect on the current period.
- R7: Each strobe pulse lasts exactly one reference cycle.
- R8: A synchronous, active-high reset clears the count, the divide-by-two toggle and both strobes, and loads the ratio and select inputs.
- R9: `ref_o` is a direct copy of the reference clock `clk_i`.
- R10: The full 12-bit range works, up to R = 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_i | input | 12 | Division ratio R |
| half_b_i | input | 1 | 1 = extra divide-by-two on loop B |
| strobe_a_o | output | 1 | Loop A comparison strobe (rising edge of divided signal) |
| strobe_b_o | output | 1 | Loop B comparison strobe (falling edge of divided signal) |
| ref_o | output | 1 | Buffered copy of the reference clock |

## Verification
The hardest case to bring about is a ratio or select change that arrives in the middle of a period. It must be shown to leave that period untouched and to apply only from the next wrap. The stimulus first waits for a loop A strobe. It then changes the inputs a few cycles later, and again right after the strobe. The cycle-by-cycle model latches inputs only at its own wrap point, so any early adoption shows up as a displaced strobe. The long 4095 period is followed by a switch to 8, which holds the new value pending for thousands of cycles.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // Lift a programmed ratio to the minimum legal value.
  function automatic int unsigned clamp_ratio(input int unsigned r, input int unsigned floor_v);
    return (r < floor_v) ? floor_v : r;
  endfunction

  // Number of cycles the divided signal spends high.
  function automatic int unsigned high_len(input int unsigned r);
    return r / 2;
  endfunction

endpackage

// File: rtl/refdiv_count.sv
module refdiv_count #(
  parameter int W     = 12,
  parameter int MIN_R = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] ratio_i,
  input  logic         half_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         wrap_o,
  output logic [W-1:0] act_ratio_o,
  output logic         act_half_o
);
  import refdiv_pkg::*;

  logic [W-1:0] cnt_q;
  logic [W-1:0] act_r_q;
  logic         act_h_q;
  logic [W-1:0] ratio_legal;
  logic         wrap;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    ratio_legal = W'(clamp_ratio(32'(ratio_i), MIN_R));
    wrap        = (cnt_q == act_r_q - W'(1));
    cnt_nxt     = wrap ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      act_r_q <= ratio_legal;
      act_h_q <= half_i;
    end else begin
      cnt_q <= cnt_nxt;
      if (wrap) begin
        act_r_q <= ratio_legal;
        act_h_q <= half_i;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign cnt_nxt_o   = cnt_nxt;
  assign wrap_o      = wrap;
  assign act_ratio_o = act_r_q;
  assign act_half_o  = act_h_q;

endmodule

// File: rtl/refdiv_edge.sv
module refdiv_edge #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] act_ratio_i,
  input  logic         act_half_i,
  output logic         rise_evt_o,
  output logic         fall_evt_o,
  output logic         tog_o,
  output logic         strobe_a_o,
  output logic         strobe_b_o
);
  import refdiv_pkg::*;

  logic [W-1:0] hi_len;
  logic         rise_evt;
  logic         fall_evt;
  logic         b_fire;
  logic         tog_q;
  logic         sa_q;
  logic         sb_q;

  always_comb begin
    hi_len   = W'(high_len(32'(act_ratio_i)));
    rise_evt = (cnt_nxt_i == '0);
    fall_evt = (cnt_nxt_i == hi_len);
    b_fire   = fall_evt && (!act_half_i || !tog_q);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tog_q <= 1'b0;
      sa_q  <= 1'b0;
      sb_q  <= 1'b0;
    end else begin
      sa_q <= rise_evt;
      sb_q <= b_fire;
      if (fall_evt) tog_q <= act_half_i ? ~tog_q : 1'b0;
    end
  end

  assign rise_evt_o = rise_evt;
  assign fall_evt_o = fall_evt;
  assign tog_o      = tog_q;
  assign strobe_a_o = sa_q;
  assign strobe_b_o = sb_q;

endmodule

// File: rtl/refdiv_dual.sv
module refdiv_dual #(
  parameter int W     = 12,
  parameter int MIN_R = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] ratio_i,
  input  logic         half_b_i,
  output logic         strobe_a_o,
  output logic         strobe_b_o,
  output logic         ref_o
);

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;
  logic         wrap_evt;
  logic [W-1:0] act_ratio;
  logic         act_half;
  logic         rise_evt;
  logic         fall_evt;
  logic         tog;

  refdiv_count #(.W(W), .MIN_R(MIN_R)) u_count (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ratio_i     (ratio_i),
    .half_i      (half_b_i),
    .cnt_o       (cnt),
    .cnt_nxt_o   (cnt_nxt),
    .wrap_o      (wrap_evt),
    .act_ratio_o (act_ratio),
    .act_half_o  (act_half)
  );

  refdiv_edge #(.W(W)) u_edge (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cnt_nxt_i   (cnt_nxt),
    .act_ratio_i (act_ratio),
    .act_half_i  (act_half),
    .rise_evt_o  (rise_evt),
    .fall_evt_o  (fall_evt),
    .tog_o       (tog),
    .strobe_a_o  (strobe_a_o),
    .strobe_b_o  (strobe_b_o)
  );

  assign ref_o = clk_i;

endmodule

// File: rtl/refdiv_dual_chk.sv
module refdiv_dual_chk #(
  parameter int W     = 12,
  parameter int MIN_R = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         strobe_a_o,
  input logic         strobe_b_o,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act_ratio,
  input logic         wrap_evt,
  input logic         fall_evt,
  input logic         act_half,
  input logic         tog
);

  assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(strobe_a_o && strobe_b_o));

  assert_pulse_a_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_a_o |=> !strobe_a_o);

  assert_pulse_b_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_b_o |=> !strobe_b_o);

  assert_reset_clear_R8: assert property (@(posedge clk_i)
    rst_i |=> (!strobe_a_o && !strobe_b_o));

  assert_count_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt < act_ratio) && (act_ratio >= W'(MIN_R)));

  assert_hold_ratio_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(wrap_evt)) |-> ($stable(act_ratio) && $stable(act_half)));

  assert_skip_second_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (fall_evt && act_half && tog) |=> !strobe_b_o);

endmodule

bind refdiv_dual refdiv_dual_chk #(.W(W), .MIN_R(MIN_R)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .strobe_a_o (strobe_a_o),
  .strobe_b_o (strobe_b_o),
  .cnt        (cnt),
  .act_ratio  (act_ratio),
  .wrap_evt   (wrap_evt),
  .fall_evt   (fall_evt),
  .act_half   (act_half),
  .tog        (tog)
);

// File: tb/refdiv_dual_tb.sv
module refdiv_dual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ratio = 12'd10;
  logic         half = 1'b0;
  logic         sa, sb, refc;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R8";

  // reference model state
  int  m_pos, m_len, m_tog;
  bit  m_half, e_a, e_b;

  refdiv_dual #(.W(W), .MIN_R(8)) u_dut (
    .clk_i(clk), .rst_i(rst), .ratio_i(ratio), .half_b_i(half),
    .strobe_a_o(sa), .strobe_b_o(sb), .ref_o(refc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int legal(input int r);
    return (r < 8) ? 8 : r;
  endfunction

  // Model: position within the period; inputs adopted only at the period boundary.
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pos = 0; m_len = legal(ratio); m_half = half; m_tog = 0;
      e_a = 0; e_b = 0;
    end else begin
      if (m_pos + 1 >= m_len) begin
        m_pos = 0; m_len = legal(ratio); m_half = half;
      end else m_pos++;
      e_a = (m_pos == 0);
      e_b = 0;
      if (m_pos == m_len / 2) begin
        if (!m_half) begin e_b = 1; m_tog = 0; end
        else begin e_b = (m_tog == 0); m_tog = 1 - m_tog; end
      end
    end
  end

  task automatic chk(input bit got, input bit exp, input string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s got %0b exp %0b at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    chk(sa, e_a, "strobe_a (R1)");
    chk(sb, e_b, "strobe_b (R3)");
    if (sa || sb) chk(sa && sb, 1'b0, "overlap (R4)");
    chk(refc, 1'b0, "ref_o low phase (R9)");
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_a();
    do @(negedge clk); while (!sa);
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    run(3);
    tag = "R8"; rst = 1'b0;
    run(25);
    tag = "R9"; @(posedge clk); #1; chk(refc, 1'b1, "ref_o high phase (R9)");
    @(negedge clk);
    tag = "R1"; run(40);
    tag = "R3"; ratio = 12'd11; run(60);
    tag = "R2"; ratio = 12'd3; run(50);
    ratio = 12'd0; run(40);
    tag = "R5"; ratio = 12'd9; half = 1'b1; run(90);
    tag = "R7"; ratio = 12'd8; run(50);
    tag = "R6"; wait_a(); ratio = 12'd20; half = 1'b0; run(60);
    wait_a(); run(5); ratio = 12'd13; half = 1'b1; run(70);
    wait_a(); run(3); ratio = 12'd17; half = 1'b0; run(60);
    tag = "R10"; ratio = 12'd4095; run(8300);
    tag = "R6"; ratio = 12'd8; run(4200);
    tag = "R8"; rst = 1'b1; ratio = 12'd12; run(2);
    rst = 1'b0; run(40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule